// File: doc/BRIEF.md
# Memory Bank Configuration Front End

This block is the register side of a memory controller that serves up to four banks. Software reaches it with only two words on a register bus. Word 0 holds a pointer. Word 1 reads or writes the inner register that the pointer selects.

Behind the pointer sit the following registers:
- error status and error address registers,
- a global configuration word and a read-only status word,
- refresh, power-management and timing words,
- one configuration word for each bank,
- ECC configuration and ECC status words.

Each bank word holds a base address, a power-of-two size code and an enable bit. The block turns these three fields into a combinational hit signal for that bank. A bank can hit only while the global enable is set. A nonzero ECC status drives an interrupt line.

A system integrator connects the register bus to `reg_*`. The upper address bits of each memory request go to `mem_addr_hi`. The `bank_hit` vector then selects which bank serves the request.

Top module: `sdram_cfg_unit`

## Requirements
- R1: A write with `reg_sel`=0 loads the 32-bit pointer. It takes effect at the next clock edge and reads back with `reg_sel`=0. With `reg_sel`=1, reads and writes go to the inner register at the pointer's byte offset. `reg_rdata` is combinational.
- R2: After reset the inner registers hold these values: configuration (0x20) 0x00800000, power management (0x34) 0x07C00000, refresh (0x30) 0x05F00000. Every other stored register and the pointer hold 0. `ecc_irq` and all `bank_hit` bits are 0.
- R3: An offset outside the set {0x00, 0x08, 0x10, 0x20, 0x24, 0x30, 0x34, 0x40, 0x44, 0x48, 0x4C, 0x94, 0x98} reads 0xFFFFFFFF. The timing word (0x80) reads 0xFFFFFFFF whatever was written to it.
- R4: Write masks. Refresh keeps 0x3FF80000. Power management keeps 0xF8000000 and always reads 0x07C00000 set in addition. ECC configuration (0x94) keeps 0x00F00000. Configuration keeps 0xFFE00000. The error address (0x10) keeps all 32 bits.
- R5: The two error status words (0x00, 0x08) are write-one-to-clear and read 0 after any write. A write to the status word (0x24) changes nothing.
- R6: When a configuration write changes bit 31 from 0 to 1, status bit 31 clears. When it changes bit 31 from 1 to 0, status bit 31 sets. A write that leaves bit 31 unchanged leaves status bit 31 alone.
- R7: When a configuration write changes bit 30 from 0 to 1, status bit 30 sets. When it changes bit 30 from 1 to 0, status bit 30 clears.
- R8: A bank word (offset 0x40 + 4*n) keeps only the bits in 0xFFDEE001. Bits 31:23 are the base, bits 19:17 the size code, and bit 0 the bank enable.
- R9: A bank with size code c (0..6) covers 4 MiB << c bytes, aligned to that size. The base gives address bits 31:23. `bank_hit[n]` is 1 exactly when the address bits 31:22 fall inside that window.
- R10: `bank_hit[n]` is 0 in any of these cases: configuration bit 31 is clear, the bank enable bit is clear, or the size code is 7.
- R11: The ECC status word (0x98) keeps 0xFFF0F000. `ecc_irq` rises when that word goes from zero to nonzero. It falls when the word is written back to zero. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the pointer, 1 selects the pointed-to register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| mem_addr_hi | input | 10 | Memory request address bits 31:22 |
| bank_hit | output | NBANK | Per-bank address hit |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
A corrupted pointer or configuration word shows up on `reg_rdata` in the same cycle it is read, because the read path is purely combinational. A wrong bank word or a wrong global enable shows up on `bank_hit` as soon as `mem_addr_hi` enters or leaves the affected window. The bench sweeps every window position for every size code on every bank, so such a fault cannot hide. A wrong interrupt state becomes visible one clock after the ECC status write that should have moved it.

// File: rtl/sdram_cfg_pkg.sv
// Package: shared offsets, masks, reset values and field positions for the
// memory bank configuration front end. Assumes a 32-bit register bus.
package sdram_cfg_pkg;
    localparam int REG_W     = 32;
    localparam int NBANK_MAX = 4;
    typedef logic [REG_W-1:0] word_t;

    // Inner register byte offsets
    localparam word_t OFF_ERRS0   = 32'h0000_0000;
    localparam word_t OFF_ERRS1   = 32'h0000_0008;
    localparam word_t OFF_ERRADDR = 32'h0000_0010;
    localparam word_t OFF_CFG     = 32'h0000_0020;
    localparam word_t OFF_STAT    = 32'h0000_0024;
    localparam word_t OFF_RFSH    = 32'h0000_0030;
    localparam word_t OFF_PWR     = 32'h0000_0034;
    localparam word_t OFF_BANK0   = 32'h0000_0040;
    localparam word_t OFF_TIMING  = 32'h0000_0080;
    localparam word_t OFF_ECCCFG  = 32'h0000_0094;
    localparam word_t OFF_ECCSTAT = 32'h0000_0098;
    localparam int    BANK_STRIDE = 4;

    // Write masks and forced bits
    localparam word_t MSK_CFG     = 32'hFFE0_0000;
    localparam word_t MSK_RFSH    = 32'h3FF8_0000;
    localparam word_t MSK_PWR     = 32'hF800_0000;
    localparam word_t FRC_PWR     = 32'h07C0_0000;
    localparam word_t MSK_ECCCFG  = 32'h00F0_0000;
    localparam word_t MSK_ECCSTAT = 32'hFFF0_F000;
    localparam word_t MSK_BANK    = 32'hFFDE_E001;

    // Reset values
    localparam word_t RST_CFG  = 32'h0080_0000;
    localparam word_t RST_PWR  = 32'h07C0_0000;
    localparam word_t RST_RFSH = 32'h05F0_0000;
    localparam word_t ALL_ONES = 32'hFFFF_FFFF;

    // Field positions
    localparam int CFG_EN_BIT   = 31;
    localparam int CFG_AUX_BIT  = 30;
    localparam int BASE_HI      = 31;
    localparam int BASE_LO      = 23;
    localparam int SZ_HI        = 19;
    localparam int SZ_LO        = 17;
    localparam int BANK_EN_BIT  = 0;
    localparam int WIN_LSB      = 22;
    localparam int BASE_W       = BASE_HI - BASE_LO + 1;
    localparam int SZ_W         = SZ_HI - SZ_LO + 1;
    localparam int WIN_W        = REG_W - WIN_LSB;
    localparam logic [SZ_W-1:0] SZ_INVALID = '1;
endpackage

// File: rtl/sdram_cfg_regs.sv
// Register file: holds the pointer and all inner registers and applies the
// write masks and the configuration side effects on status. It also keeps
// the ECC interrupt flop. Assumes NBANK <= 4 and that reg_wr is a
// single-cycle strobe.
module sdram_cfg_regs
    import sdram_cfg_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic                   reg_sel,
    input  word_t                  reg_wdata,
    output word_t                  ind_addr,
    output word_t                  errs0_q,
    output word_t                  errs1_q,
    output word_t                  erraddr_q,
    output word_t                  cfg_q,
    output word_t                  stat_q,
    output word_t                  rfsh_q,
    output word_t                  pwr_q,
    output word_t                  ecccfg_q,
    output word_t                  eccstat_q,
    output logic [NBANK-1:0][REG_W-1:0] bank_q,
    output logic                   ecc_irq
);
    logic  wr_ptr, wr_inner;
    word_t cfg_next, stat_next, ecc_next;

    assign wr_ptr   = reg_wr && !reg_sel;
    assign wr_inner = reg_wr &&  reg_sel;
    assign ecc_next = reg_wdata & MSK_ECCSTAT;

    // Next configuration word and its status side effects
    always_comb begin
        cfg_next  = reg_wdata & MSK_CFG;
        stat_next = stat_q;
        if (!cfg_q[CFG_EN_BIT] && cfg_next[CFG_EN_BIT])
            stat_next[CFG_EN_BIT] = 1'b0;
        else if (cfg_q[CFG_EN_BIT] && !cfg_next[CFG_EN_BIT])
            stat_next[CFG_EN_BIT] = 1'b1;
        if (!cfg_q[CFG_AUX_BIT] && cfg_next[CFG_AUX_BIT])
            stat_next[CFG_AUX_BIT] = 1'b1;
        else if (cfg_q[CFG_AUX_BIT] && !cfg_next[CFG_AUX_BIT])
            stat_next[CFG_AUX_BIT] = 1'b0;
    end

    // Register state update on pointer and inner writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ind_addr  <= '0;
            errs0_q   <= '0;
            errs1_q   <= '0;
            erraddr_q <= '0;
            cfg_q     <= RST_CFG;
            stat_q    <= '0;
            rfsh_q    <= RST_RFSH;
            pwr_q     <= RST_PWR;
            ecccfg_q  <= '0;
            eccstat_q <= '0;
            bank_q    <= '0;
            ecc_irq   <= 1'b0;
        end else begin
            if (wr_ptr)
                ind_addr <= reg_wdata;
            if (wr_inner) begin
                case (ind_addr)
                    OFF_ERRS0:   errs0_q   <= errs0_q & ~reg_wdata;
                    OFF_ERRS1:   errs1_q   <= errs1_q & ~reg_wdata;
                    OFF_ERRADDR: erraddr_q <= reg_wdata;
                    OFF_CFG: begin
                        cfg_q  <= cfg_next;
                        stat_q <= stat_next;
                    end
                    OFF_RFSH:    rfsh_q   <= reg_wdata & MSK_RFSH;
                    OFF_PWR:     pwr_q    <= (reg_wdata & MSK_PWR) | FRC_PWR;
                    OFF_ECCCFG:  ecccfg_q <= reg_wdata & MSK_ECCCFG;
                    OFF_ECCSTAT: begin
                        eccstat_q <= ecc_next;
                        if (eccstat_q == '0 && ecc_next != '0)
                            ecc_irq <= 1'b1;
                        else if (eccstat_q != '0 && ecc_next == '0)
                            ecc_irq <= 1'b0;
                    end
                    default: ;
                endcase
                for (int b = 0; b < NBANK; b++) begin
                    if (ind_addr == OFF_BANK0 + word_t'(b * BANK_STRIDE))
                        bank_q[b] <= reg_wdata & MSK_BANK;
                end
            end
        end
    end
endmodule

// File: rtl/sdram_cfg_rdmux.sv
// Read multiplexer: returns the pointer when reg_sel is 0. When reg_sel is
// 1 it returns the inner register the pointer selects. Unknown offsets and
// the timing word read all ones. Purely combinational.
module sdram_cfg_rdmux
    import sdram_cfg_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic                   reg_sel,
    input  word_t                  ind_addr,
    input  word_t                  errs0_q,
    input  word_t                  errs1_q,
    input  word_t                  erraddr_q,
    input  word_t                  cfg_q,
    input  word_t                  stat_q,
    input  word_t                  rfsh_q,
    input  word_t                  pwr_q,
    input  word_t                  ecccfg_q,
    input  word_t                  eccstat_q,
    input  logic [NBANK-1:0][REG_W-1:0] bank_q,
    output word_t                  reg_rdata
);
    word_t inner;

    // Select the inner register addressed by the pointer
    always_comb begin
        case (ind_addr)
            OFF_ERRS0:   inner = errs0_q;
            OFF_ERRS1:   inner = errs1_q;
            OFF_ERRADDR: inner = erraddr_q;
            OFF_CFG:     inner = cfg_q;
            OFF_STAT:    inner = stat_q;
            OFF_RFSH:    inner = rfsh_q;
            OFF_PWR:     inner = pwr_q;
            OFF_ECCCFG:  inner = ecccfg_q;
            OFF_ECCSTAT: inner = eccstat_q;
            default:     inner = ALL_ONES;
        endcase
        for (int b = 0; b < NBANK; b++) begin
            if (ind_addr == OFF_BANK0 + word_t'(b * BANK_STRIDE))
                inner = bank_q[b];
        end
    end

    assign reg_rdata = reg_sel ? inner : ind_addr;
endmodule

// File: rtl/sdram_bank_dec.sv
// Single-bank address decoder: compares address bits 31:22 against the
// bank base, ignoring the low bits covered by the size code. Assumes a
// 4 MiB unit for code 0; code 7 never hits.
module sdram_bank_dec
    import sdram_cfg_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic [SZ_W-1:0]   code,
    input  logic              bank_en,
    input  logic              glb_en,
    input  logic [WIN_W-1:0]  win_addr,
    output logic              hit
);
    localparam int PAD = WIN_W - BASE_W;

    logic [WIN_W-1:0] win_base, care;

    assign win_base = {base, {PAD{1'b0}}};
    assign care     = {WIN_W{1'b1}} << code;

    // Window match gated by both enables and a valid size code
    always_comb begin
        hit = glb_en && bank_en && (code != SZ_INVALID)
              && (((win_addr ^ win_base) & care) == '0);
    end
endmodule

// File: rtl/sdram_cfg_unit.sv
// Top of the memory bank configuration front end: indirect register access,
// per-bank address hit decode and ECC interrupt. Synchronous active-low
// reset. Assumes NBANK <= 4.
module sdram_cfg_unit
    import sdram_cfg_pkg::*;
#(
    parameter int NBANK = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [WIN_W-1:0]     mem_addr_hi,
    output logic [NBANK-1:0]     bank_hit,
    output logic                 ecc_irq
);
    word_t ind_addr, errs0_q, errs1_q, erraddr_q, cfg_q, stat_q;
    word_t rfsh_q, pwr_q, ecccfg_q, eccstat_q;
    logic [NBANK-1:0][REG_W-1:0] bank_words;
    logic [NBANK-1:0][SZ_W-1:0]  bank_codes;
    logic glb_en;

    assign glb_en = cfg_q[CFG_EN_BIT];

    sdram_cfg_regs #(.NBANK(NBANK)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ind_addr(ind_addr), .errs0_q(errs0_q),
        .errs1_q(errs1_q), .erraddr_q(erraddr_q), .cfg_q(cfg_q),
        .stat_q(stat_q), .rfsh_q(rfsh_q), .pwr_q(pwr_q),
        .ecccfg_q(ecccfg_q), .eccstat_q(eccstat_q), .bank_q(bank_words),
        .ecc_irq(ecc_irq)
    );

    sdram_cfg_rdmux #(.NBANK(NBANK)) i_rdmux (
        .reg_sel(reg_sel), .ind_addr(ind_addr), .errs0_q(errs0_q),
        .errs1_q(errs1_q), .erraddr_q(erraddr_q), .cfg_q(cfg_q),
        .stat_q(stat_q), .rfsh_q(rfsh_q), .pwr_q(pwr_q),
        .ecccfg_q(ecccfg_q), .eccstat_q(eccstat_q), .bank_q(bank_words),
        .reg_rdata(reg_rdata)
    );

    // One decoder per bank
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign bank_codes[g] = bank_words[g][SZ_HI:SZ_LO];
        sdram_bank_dec i_dec (
            .base(bank_words[g][BASE_HI:BASE_LO]),
            .code(bank_codes[g]),
            .bank_en(bank_words[g][BANK_EN_BIT]),
            .glb_en(glb_en),
            .win_addr(mem_addr_hi),
            .hit(bank_hit[g])
        );
    end
endmodule

// File: rtl/sdram_cfg_chk.sv
// Checker: temporal properties of the configuration front end, bound to
// sdram_cfg_unit. Assumes the same package constants as the design.
module sdram_cfg_chk
    import sdram_cfg_pkg::*;
#(
    parameter int NBANK = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_wr,
    input logic                        reg_sel,
    input logic [REG_W-1:0]            reg_wdata,
    input logic [REG_W-1:0]            reg_rdata,
    input logic [REG_W-1:0]            ind_addr,
    input logic [REG_W-1:0]            stat_q,
    input logic                        glb_en,
    input logic [NBANK-1:0][SZ_W-1:0]  bank_codes,
    input logic [NBANK-1:0]            bank_hit,
    input logic                        ecc_irq
);
    logic cfg_wr, ecc_wr;
    assign cfg_wr = reg_wr && reg_sel && ind_addr == OFF_CFG;
    assign ecc_wr = reg_wr && reg_sel && ind_addr == OFF_ECCSTAT;

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel) |=> ind_addr == $past(reg_wdata)); // R1
    AST_TIMING_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && ind_addr == OFF_TIMING) |-> reg_rdata == ALL_ONES); // R3
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(stat_q)); // R6
    AST_NO_HIT_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> bank_hit == '0); // R10
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_wr && (reg_wdata & MSK_ECCSTAT) != '0) |=> ecc_irq); // R11
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_wr && (reg_wdata & MSK_ECCSTAT) == '0) |=> !ecc_irq); // R11
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_wr |=> $stable(ecc_irq)); // R11

    for (genvar g = 0; g < NBANK; g++) begin : g_code
        AST_CODE7_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            bank_codes[g] == SZ_INVALID |-> !bank_hit[g]); // R10
    end
endmodule

bind sdram_cfg_unit sdram_cfg_chk #(.NBANK(NBANK)) i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ind_addr(ind_addr),
    .stat_q(stat_q), .glb_en(glb_en), .bank_codes(bank_codes),
    .bank_hit(bank_hit), .ecc_irq(ecc_irq)
);

// File: tb/test_sdram_cfg_unit.sv
// Self-checking bench: offset sweep, mask and side-effect checks,
// exhaustive window sweep per bank and size code.
module test_sdram_cfg_unit;
    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [9:0]  mem_addr_hi = '0;
    logic [NB-1:0] bank_hit;
    logic        ecc_irq;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    sdram_cfg_unit #(.NBANK(NB)) i_sdram_cfg_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_addr_hi(mem_addr_hi), .bank_hit(bank_hit), .ecc_irq(ecc_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [31:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wri(input logic [31:0] off, input logic [31:0] v);
        wr(1'b0, off);
        wr(1'b1, v);
    endtask

    task automatic rd(input logic [31:0] off, output logic [31:0] v);
        wr(1'b0, off);
        reg_sel = 1'b1;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] reset_read(input int off);
        case (off)
            'h20: return 32'h0080_0000;
            'h30: return 32'h05F0_0000;
            'h34: return 32'h07C0_0000;
            'h00, 'h08, 'h10, 'h24, 'h40, 'h44, 'h48, 'h4C, 'h94, 'h98: return 32'h0;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Window model: 4 MiB units, aligned region of 2^code units
    function automatic logic exp_hit(input logic [31:0] w, input logic g, input int a);
        int code, units, start;
        code = int'(w[19:17]);
        if (!g || !w[0] || code == 7) return 1'b0;
        units = 1 << code;
        start = (int'(w[31:23]) * 2) / units * units;
        return (a >= start) && (a < start + units);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2 pointer reset", reg_rdata, 32'h0);
        chk("R2 irq reset", {31'h0, ecc_irq}, 32'h0);
        chk("R2 hits reset", {28'h0, bank_hit}, 32'h0);

        // R2/R3: every byte offset 0..255 right after reset
        for (int o = 0; o < 256; o++) begin
            rd(o, v);
            chk("R3 offset sweep", v, reset_read(o));
        end
        wr(1'b0, 32'h1234_5678);
        reg_sel = 1'b0; #1;
        chk("R1 pointer readback", reg_rdata, 32'h1234_5678);

        // R4 masks
        wri(32'h30, 32'hFFFF_FFFF); rd(32'h30, v); chk("R4 refresh", v, 32'h3FF8_0000);
        wri(32'h34, 32'h0);         rd(32'h34, v); chk("R4 pwr forced", v, 32'h07C0_0000);
        wri(32'h34, 32'hFFFF_FFFF); rd(32'h34, v); chk("R4 pwr full", v, 32'hFFC0_0000);
        wri(32'h94, 32'hFFFF_FFFF); rd(32'h94, v); chk("R4 ecc cfg", v, 32'h00F0_0000);
        wri(32'h10, 32'hA5A5_5A5A); rd(32'h10, v); chk("R4 err addr", v, 32'hA5A5_5A5A);
        wri(32'h80, 32'h0);         rd(32'h80, v); chk("R3 timing", v, 32'hFFFF_FFFF);

        // R5
        wri(32'h00, 32'hFFFF_FFFF); rd(32'h00, v); chk("R5 err status 0", v, 32'h0);
        wri(32'h08, 32'hFFFF_FFFF); rd(32'h08, v); chk("R5 err status 1", v, 32'h0);
        wri(32'h24, 32'hFFFF_FFFF); rd(32'h24, v); chk("R5 status ro", v, 32'h0);

        // R6/R7 configuration side effects
        wri(32'h20, 32'h8000_0000); rd(32'h20, v); chk("R4 cfg", v, 32'h8000_0000);
        rd(32'h24, v); chk("R6 enable on", v, 32'h0);
        wri(32'h20, 32'hC000_0000); rd(32'h24, v); chk("R7 aux on", v, 32'h4000_0000);
        wri(32'h20, 32'h0);         rd(32'h24, v); chk("R6 R7 both off", v, 32'h8000_0000);
        wri(32'h20, 32'hFFFF_FFFF); rd(32'h20, v); chk("R4 cfg mask", v, 32'hFFE0_0000);
        rd(32'h24, v); chk("R6 R7 both on", v, 32'h4000_0000);
        wri(32'h20, 32'h4000_0000); rd(32'h24, v); chk("R6 off aux held", v, 32'hC000_0000);
        wri(32'h24, 32'h0);         rd(32'h24, v); chk("R5 status write ignored", v, 32'hC000_0000);
        wri(32'h20, 32'h4000_0000); rd(32'h24, v); chk("R6 no transition", v, 32'hC000_0000);
        wri(32'h20, 32'h8000_0000); rd(32'h24, v); chk("R6 R7 swap", v, 32'h0);

        // R8 bank word masks
        for (int b = 0; b < NB; b++) begin
            wri(32'h40 + 32'(4*b), 32'hFFFF_FFFF); rd(32'h40 + 32'(4*b), v);
            chk("R8 bank mask", v, 32'hFFDE_E001);
            wri(32'h40 + 32'(4*b), 32'h0); rd(32'h40 + 32'(4*b), v);
            chk("R8 bank clear", v, 32'h0);
        end

        // R11 ECC status and interrupt
        wri(32'h98, 32'h000F_0FFF); rd(32'h98, v); chk("R11 masked zero", v, 32'h0);
        chk("R11 irq stays low", {31'h0, ecc_irq}, 32'h0);
        wri(32'h98, 32'h0010_0000);
        chk("R11 irq rises", {31'h0, ecc_irq}, 32'h1);
        wri(32'h98, 32'hFFFF_FFFF); rd(32'h98, v); chk("R11 ecc mask", v, 32'hFFF0_F000);
        chk("R11 irq held", {31'h0, ecc_irq}, 32'h1);
        wri(32'h98, 32'h0);
        chk("R11 irq falls", {31'h0, ecc_irq}, 32'h0);

        // R9/R10 exhaustive window sweep, global enable on
        reg_sel = 1'b0;
        for (int c = 0; c < 8; c++) begin
            for (int b = 0; b < NB; b++) begin
                logic [31:0] w;
                logic [8:0]  base;
                base = 9'((9'h0A3 * (b + 1) + c * 37));
                w = {base, 3'b0, 3'(c), 16'h0, 1'b1};
                wri(32'h40 + 32'(4*b), w);
                for (int a = 0; a < 1024; a++) begin
                    @(negedge clk);
                    mem_addr_hi = 10'(a);
                    #1;
                    for (int k = 0; k < NB; k++)
                        chk(c == 7 ? "R10 code 7" : "R9 window",
                            {31'h0, bank_hit[k]},
                            {31'h0, (k == b) ? exp_hit(w, 1'b1, a) : 1'b0});
                end
                // Bank enable cleared: R10
                wri(32'h40 + 32'(4*b), w & ~32'h1);
                for (int a = 0; a < 1024; a += 64) begin
                    @(negedge clk); mem_addr_hi = 10'(a); #1;
                    chk("R10 bank disabled", {28'h0, bank_hit}, 32'h0);
                end
                wri(32'h40 + 32'(4*b), 32'h0);
            end
        end

        // R10 global enable gates all banks
        for (int b = 0; b < NB; b++)
            wri(32'h40 + 32'(4*b), {9'(b * 64), 3'b0, 3'd6, 16'h0, 1'b1});
        wri(32'h20, 32'h0);
        for (int a = 0; a < 1024; a += 8) begin
            @(negedge clk); mem_addr_hi = 10'(a); #1;
            chk("R10 global off", {28'h0, bank_hit}, 32'h0);
        end
        wri(32'h20, 32'h8000_0000);
        for (int a = 0; a < 1024; a += 8) begin
            @(negedge clk); mem_addr_hi = 10'(a); #1;
            for (int k = 0; k < NB; k++)
                chk("R9 multi bank", {31'h0, bank_hit[k]},
                    {31'h0, exp_hit({9'(k * 64), 3'b0, 3'd6, 16'h0, 1'b1}, 1'b1, a)});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule